// File: doc/BRIEF.md
# ECC-Safe Write Strobe Checker

This block watches, without driving anything, an AXI write path that feeds a cache with error correction enabled. Such a cache computes its check bits over 64-bit words, so any cacheable write that starts off an 8-byte boundary or leaves an 8-byte word partly written corrupts the stored code beyond repair. The monitor samples the address handshake, follows every data beat of the transaction, and records each rule that was broken.

The data width is a parameter (32, 64 or 128 bits). The strobe rule follows it. A 32-bit bus must fill each beat and use a burst of 2, 4, 8 or 16 beats. A 64-bit bus must fill every beat. A 128-bit bus may fill either 8-byte half or both, but must never fill only part of a half. Faults build up in a sticky four-bit code until a clear input is pulsed. The monitor assumes one transaction at a time, with the address handshake accepted before the first data beat.

Top module: `wstrb_ecc_monitor`

## Requirements
- R1: A cacheable address handshake with `aw_addr_lo` not equal to 0 sets bit 0 (alignment fault) of `err_code`.
- R2: With DATA_W = 32, a cacheable address handshake whose `aw_len` is not 1, 3, 7 or 15 (burst of 2, 4, 8 or 16 beats) sets bit 1 (burst-length fault). With DATA_W of 64 or 128, bit 1 is never set.
- R3: With DATA_W = 32, any cacheable data beat with a strobe bit low sets bit 2 (strobe fault).
- R4: With DATA_W = 64, any cacheable data beat that does not have all eight strobes high sets bit 2.
- R5: With DATA_W = 128, a cacheable beat sets bit 2 unless each 8-strobe half (bits 7:0 and 15:8) is either all high or all low, and at least one half is all high.
- R6: A transaction whose address handshake has `aw_cacheable` low sets no bit, whatever its address, length, strobes or last flag.
- R7: In a cacheable transaction, a beat with `w_last` high before beat `aw_len`+1, or beat `aw_len`+1 arriving with `w_last` low, sets bit 3 (last-beat fault). The transaction ends on either of these beats.
- R8: The code bits are sticky. `err_flag` is the OR of the code bits. A `clr` pulse zeroes the code on the next edge, but a fault detected in that same cycle is still recorded.
- R9: After reset the code and flag are zero. A fault sets its bit on the rising edge that samples the offending handshake, so it is visible one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Clears the sticky fault code |
| aw_valid | input | 1 | Write address valid (tapped) |
| aw_ready | input | 1 | Write address ready (tapped) |
| aw_addr_lo | input | 3 | Low three address bits |
| aw_len | input | LEN_W | Burst length minus one |
| aw_cacheable | input | 1 | Cacheable attribute bit of the write cache field |
| w_valid | input | 1 | Write data valid (tapped) |
| w_ready | input | 1 | Write data ready (tapped) |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Last beat marker |
| err_flag | output | 1 | Any fault recorded |
| err_code | output | 4 | Sticky fault bits: 0 align, 1 burst length, 2 strobe, 3 last |

## Verification
Every fault is registered once, on the edge that samples the address handshake or data beat that causes it. The result is therefore due one clock after that stimulus. The bench drives on falling edges and reads the outputs on the falling edge that follows the capturing rising edge. The table tests read the code only after the final beat of each transaction. A directed test reads the flag one clock after a misaligned address handshake, before any data moves, and another places a clear and a new fault in the same cycle.

// File: rtl/wsc_pkg.sv
`timescale 1ns/1ps
// Package: shared fault-code layout for the write strobe monitor.
// Assumes: the four fault bits are decoded by software in this order.
package wsc_pkg;
    localparam int ERR_W     = 4;
    localparam int ERR_ALIGN = 0;
    localparam int ERR_BLEN  = 1;
    localparam int ERR_STRB  = 2;
    localparam int ERR_LAST  = 3;
    typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/wsc_addr_check.sv
`timescale 1ns/1ps
// Module: wsc_addr_check
// Checks one address handshake for 8-byte alignment and, on 32-bit
// buses, for a legal burst length. Purely combinational.
// Assumes: hs is high for exactly the cycle the handshake completes.
module wsc_addr_check #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8
) (
    input  logic             hs,
    input  logic             cacheable,
    input  logic [2:0]       addr_lo,
    input  logic [LEN_W-1:0] len,
    output logic             align_err,
    output logic             len_err
);
    logic len_ok;

    // Alignment fault: cacheable handshake off an 8-byte boundary.
    always_comb align_err = hs && cacheable && (addr_lo != 3'd0);

    generate
        if (DATA_W == 32) begin : g_narrow
            // Narrow bus: only 2, 4, 8 or 16 beat bursts are legal.
            always_comb len_ok = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                                 (len == LEN_W'(7)) || (len == LEN_W'(15));
        end else begin : g_wide
            // Wide bus: any length is legal.
            always_comb len_ok = 1'b1;
        end
    endgenerate

    // Length fault only on a cacheable handshake.
    always_comb len_err = hs && cacheable && !len_ok;
endmodule

// File: rtl/wsc_strb_check.sv
`timescale 1ns/1ps
// Module: wsc_strb_check
// Splits the strobes into 8-byte groups (one short group on a 32-bit
// bus) and accepts a beat only if every group is full or empty and at
// least one group is full. Purely combinational.
// Assumes: STRB_W is 4, 8 or 16.
module wsc_strb_check #(
    parameter int STRB_W = 8
) (
    input  logic [STRB_W-1:0] strb,
    output logic              strb_ok
);
    localparam int GRP_B = (STRB_W < 8) ? STRB_W : 8;
    localparam int N_GRP = STRB_W / GRP_B;

    logic [N_GRP-1:0] grp_full;
    logic [N_GRP-1:0] grp_empty;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            // Per-group full and empty detection.
            always_comb begin
                grp_full[g]  = &strb[g*GRP_B +: GRP_B];
                grp_empty[g] = ~|strb[g*GRP_B +: GRP_B];
            end
        end
    endgenerate

    // Beat is legal when no group is partial and one group is written.
    always_comb strb_ok = (&(grp_full | grp_empty)) && (|grp_full);
endmodule

// File: rtl/wsc_beat_tracker.sv
`timescale 1ns/1ps
// Module: wsc_beat_tracker
// Holds the open transaction (cacheable attribute and length), counts
// its data beats and compares the last marker with the count.
// Assumes: address handshake precedes data, one transaction open at a time.
module wsc_beat_tracker #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aw_hs,
    input  logic             aw_cacheable,
    input  logic [LEN_W-1:0] aw_len,
    input  logic             w_hs,
    input  logic             w_last,
    output logic             beat_chk,
    output logic             last_err
);
    logic             active_q;
    logic             chk_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             beat_evt;
    logic             final_beat;
    logic             txn_end;

    // Decode the current beat against the open transaction.
    always_comb begin
        beat_evt   = w_hs && active_q;
        final_beat = (cnt_q == len_q);
        txn_end    = beat_evt && (w_last || final_beat);
        beat_chk   = beat_evt && chk_q;
        last_err   = beat_chk && (w_last != final_beat);
    end

    // Open on address handshake, count beats, close on last or final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            chk_q    <= 1'b0;
            len_q    <= '0;
            cnt_q    <= '0;
        end else if (aw_hs) begin
            active_q <= 1'b1;
            chk_q    <= aw_cacheable;
            len_q    <= aw_len;
            cnt_q    <= '0;
        end else if (txn_end) begin
            active_q <= 1'b0;
        end else if (beat_evt) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= len_q)); // R7
endmodule

// File: rtl/wstrb_ecc_monitor.sv
`timescale 1ns/1ps
// Module: wstrb_ecc_monitor (top)
// Passive monitor for cacheable writes into an ECC-protected cache.
// Combines address, strobe and beat checks into a sticky fault code.
// Assumes: DATA_W is 32, 64 or 128; taps only, drives nothing on the bus.
module wstrb_ecc_monitor
    import wsc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [2:0]        aw_addr_lo,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic              aw_cacheable,
    input  logic              w_valid,
    input  logic              w_ready,
    input  logic [STRB_W-1:0] w_strb,
    input  logic              w_last,
    output logic              err_flag,
    output logic [ERR_W-1:0]  err_code
);
    logic     aw_hs;
    logic     w_hs;
    logic     align_err;
    logic     len_err;
    logic     strb_ok;
    logic     beat_chk;
    logic     last_err;
    err_vec_t new_err;
    err_vec_t err_q;

    // Handshake detection on both channels.
    always_comb begin
        aw_hs = aw_valid && aw_ready;
        w_hs  = w_valid && w_ready;
    end

    wsc_addr_check #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_addr (
        .hs        (aw_hs),
        .cacheable (aw_cacheable),
        .addr_lo   (aw_addr_lo),
        .len       (aw_len),
        .align_err (align_err),
        .len_err   (len_err)
    );

    wsc_strb_check #(.STRB_W(STRB_W)) u_strb (
        .strb    (w_strb),
        .strb_ok (strb_ok)
    );

    wsc_beat_tracker #(.LEN_W(LEN_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .aw_hs        (aw_hs),
        .aw_cacheable (aw_cacheable),
        .aw_len       (aw_len),
        .w_hs         (w_hs),
        .w_last       (w_last),
        .beat_chk     (beat_chk),
        .last_err     (last_err)
    );

    // Collect this cycle's faults into code positions.
    always_comb begin
        new_err            = '0;
        new_err[ERR_ALIGN] = align_err;
        new_err[ERR_BLEN]  = len_err;
        new_err[ERR_STRB]  = beat_chk && !strb_ok;
        new_err[ERR_LAST]  = last_err;
    end

    // Sticky accumulation; clear drops old faults, new ones still land.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (clr ? '0 : err_q) | new_err;
    end

    // Drive outputs from the sticky register.
    always_comb begin
        err_code = err_q;
        err_flag = |err_q;
    end

    AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && aw_cacheable && aw_addr_lo != 3'd0)
            |=> err_code[ERR_ALIGN]); // R1
    AST_EMPTY_BEAT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_chk && w_valid && w_strb == '0) |=> err_code[ERR_STRB]); // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_code & $past(err_code)) == $past(err_code))); // R8
    AST_FLAG_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (new_err != '0) |=> err_flag); // R9
endmodule

// File: tb/wstrb_ecc_monitor_test.sv
`timescale 1ns/1ps
module wstrb_ecc_monitor_test;
    // Vector fields: addr_lo, len, cacheable, strb16, last mode, exp32, exp64, exp128
    // last mode: 0 correct, 1 early last on beat 1, 2 last never asserted
    localparam int NV = 13;
    localparam logic [41:0] VEC [NV] = '{
        {3'd0, 8'd3,  1'b1, 16'hFFFF, 2'd0, 4'h0, 4'h0, 4'h0}, // clean 4-beat
        {3'd4, 8'd3,  1'b1, 16'hFFFF, 2'd0, 4'h1, 4'h1, 4'h1}, // R1
        {3'd0, 8'd2,  1'b1, 16'hFFFF, 2'd0, 4'h2, 4'h0, 4'h0}, // R2
        {3'd0, 8'd1,  1'b1, 16'h00FF, 2'd0, 4'h0, 4'h0, 4'h0}, // R5 low half
        {3'd0, 8'd1,  1'b1, 16'hFF00, 2'd0, 4'h4, 4'h4, 4'h0}, // R3 R4 R5 high half
        {3'd0, 8'd1,  1'b1, 16'h0F0F, 2'd0, 4'h0, 4'h4, 4'h4}, // R4 R5 partial group
        {3'd0, 8'd0,  1'b1, 16'hFFFF, 2'd0, 4'h2, 4'h0, 4'h0}, // R2 single beat
        {3'd0, 8'd3,  1'b1, 16'hFFFF, 2'd1, 4'h8, 4'h8, 4'h8}, // R7 early
        {3'd0, 8'd3,  1'b1, 16'hFFFF, 2'd2, 4'h8, 4'h8, 4'h8}, // R7 missing
        {3'd2, 8'd4,  1'b0, 16'h0001, 2'd2, 4'h0, 4'h0, 4'h0}, // R6
        {3'd1, 8'd5,  1'b1, 16'h0007, 2'd0, 4'h7, 4'h5, 4'h5}, // R1 R2 R3
        {3'd0, 8'd15, 1'b1, 16'hFFFF, 2'd0, 4'h0, 4'h0, 4'h0}, // R2 16 beats
        {3'd0, 8'd7,  1'b1, 16'h0000, 2'd0, 4'h4, 4'h4, 4'h4}  // R3 R4 R5 empty
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        aw_valid = 1'b0, aw_ready = 1'b0, aw_cacheable = 1'b0;
    logic [2:0]  aw_addr_lo = '0;
    logic [7:0]  aw_len = '0;
    logic        w_valid = 1'b0, w_ready = 1'b0, w_last = 1'b0;
    logic [15:0] strb16 = '0;
    logic        f32, f64, f128;
    logic [3:0]  c32, c64, c128;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    wstrb_ecc_monitor #(.DATA_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr_lo(aw_addr_lo), .aw_len(aw_len), .aw_cacheable(aw_cacheable),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(strb16[7:0]), .w_last(w_last),
        .err_flag(f64), .err_code(c64));
    wstrb_ecc_monitor #(.DATA_W(32)) uut_n (
        .clk(clk), .rst_n(rst_n), .clr(clr), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr_lo(aw_addr_lo), .aw_len(aw_len), .aw_cacheable(aw_cacheable),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(strb16[3:0]), .w_last(w_last),
        .err_flag(f32), .err_code(c32));
    wstrb_ecc_monitor #(.DATA_W(128)) uut_w (
        .clk(clk), .rst_n(rst_n), .clr(clr), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr_lo(aw_addr_lo), .aw_len(aw_len), .aw_cacheable(aw_cacheable),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(strb16), .w_last(w_last),
        .err_flag(f128), .err_code(c128));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after capture.
    task automatic send_aw(input logic [2:0] a, input logic [7:0] l, input logic c);
        aw_valid = 1'b1; aw_ready = 1'b1; aw_addr_lo = a; aw_len = l; aw_cacheable = c;
        @(negedge clk);
        aw_valid = 1'b0; aw_ready = 1'b0;
    endtask

    task automatic send_beats(input logic [7:0] l, input logic [15:0] s, input logic [1:0] mode);
        int n;
        n = (mode == 2'd1) ? 1 : int'(l) + 1;
        for (int i = 0; i < n; i++) begin
            w_valid = 1'b1; w_ready = 1'b1; strb16 = s;
            w_last = (mode == 2'd1) ? 1'b1 : (mode == 2'd0 && i == n - 1);
            @(negedge clk);
        end
        w_valid = 1'b0; w_ready = 1'b0; w_last = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    function automatic string vtag(input int k);
        case (k)
            1: return "R1";  2: return "R2";  3: return "R5";  4: return "R3";
            5: return "R4";  6: return "R2";  7: return "R7";  8: return "R7";
            9: return "R6";  10: return "R1"; 11: return "R2"; 12: return "R3";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset code32", {4'h0, c32}, 8'h00);
        check("R9 reset code64", {4'h0, c64}, 8'h00);
        check("R9 reset code128", {4'h0, c128}, 8'h00);
        check("R9 reset flags", {5'h0, f32, f64, f128}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            pulse_clr();
            send_aw(VEC[k][41:39], VEC[k][38:31], VEC[k][30]);
            send_beats(VEC[k][38:31], VEC[k][29:14], VEC[k][13:12]);
            check($sformatf("%s vec%0d w32", vtag(k), k), {4'h0, c32}, {4'h0, VEC[k][11:8]});
            check($sformatf("%s vec%0d w64", vtag(k), k), {4'h0, c64}, {4'h0, VEC[k][7:4]});
            check($sformatf("%s vec%0d w128", vtag(k), k), {4'h0, c128}, {4'h0, VEC[k][3:0]});
            check($sformatf("R8 vec%0d flags", k), {5'h0, f32, f64, f128},
                  {5'h0, VEC[k][11:8] != 0, VEC[k][7:4] != 0, VEC[k][3:0] != 0});
        end

        // R9: fault visible one clock after the address handshake
        pulse_clr();
        check("R9 flag clear before", {7'h0, f64}, 8'h00);
        send_aw(3'd3, 8'd1, 1'b1);
        check("R9 flag one clock after aw", {7'h0, f64}, 8'h01);
        send_beats(8'd1, 16'hFFFF, 2'd0);
        check("R1 align only", {4'h0, c64}, 8'h01);

        // R8: sticky across a clean transaction
        send_aw(3'd0, 8'd3, 1'b1);
        send_beats(8'd3, 16'hFFFF, 2'd0);
        check("R8 sticky hold", {4'h0, c64}, 8'h01);

        // R8: clear zeroes the code
        pulse_clr();
        check("R8 clear", {4'h0, c64}, 8'h00);

        // R8: clear and new fault in the same cycle, fault wins
        send_aw(3'd0, 8'd1, 1'b1);
        send_beats(8'd1, 16'hFFFF, 2'd0);
        send_aw(3'd0, 8'd1, 1'b1);
        send_beats(8'd1, 16'hFFFF, 2'd2);
        check("R7 missing last recorded", {4'h0, c64}, 8'h08);
        clr = 1'b1;
        send_aw(3'd6, 8'd1, 1'b1);
        clr = 1'b0;
        check("R8 clear with new fault", {4'h0, c64}, 8'h01);
        send_beats(8'd1, 16'hFFFF, 2'd0);

        // R6: non-cacheable misaligned, wrong length, bad strobes, bad last
        pulse_clr();
        send_aw(3'd5, 8'd2, 1'b0);
        send_beats(8'd2, 16'h0003, 2'd1);
        check("R6 noncacheable w32", {4'h0, c32}, 8'h00);
        check("R6 noncacheable w128", {4'h0, c128}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule